// File: doc/BRIEF.md
# Key-Sequence Register Lock Controller

This block protects the control register of a flash controller. After reset the control register is locked. While it is locked, software can change nothing in it except the lock bit itself. To open it, software writes two fixed 32-bit values, in a fixed order, to a dedicated key address on a simple register port. Once the register is open, software can update its fields and can close it again at any time by writing the lock bit.

A key write that does not match the value the sequence expects is treated as an attack or a software fault. The block answers it with a bus error in the same cycle and enters a hard lock. The hard lock can only be left through system reset, and while it holds, even a correct key pair cannot open the register. This gives a run-time write protection that software can engage on purpose, for example by writing all ones to the key address.

Top module: `key_lock_ctrl`

## Requirements
- R1: After reset, `locked_o` is 1 and reading the control address returns 0x80000000 (lock at bit 31, field bits [15:0] all zero).
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key address while locked clears the lock; `locked_o` reads 0 in the cycle after the second write.
- R3: A key write while locked whose value is not the one the sequence expects (for example 0xFFFFFFFF as the first key) drives `err_o` high during that write cycle only.
- R4: After a faulting key write, every later key write drives `err_o`, and a correct key pair leaves `locked_o` at 1.
- R5: Writing the second key first is a faulting key write.
- R6: Writing the first key twice in a row is a faulting key write on the second write.
- R7: A control write with bit 31 set while unlocked sets the lock in the next cycle, and the field bits [15:0] of the same write are stored.
- R8: While locked, control writes leave the field bits and the lock bit unchanged.
- R9: While unlocked, key writes have no effect and raise no error.
- R10: While unlocked, a control write stores field bits [15:0] and they read back from the control address.
- R11: Reset clears the hard lock: after reset, the correct key pair unlocks again.
- R12: A control write between the first and the second key does not break the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 4 | Register address (key at 0x4, control at 0x8) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`; control register or zero |
| err_o | output | 1 | Bus error for a faulting key write, same cycle |
| locked_o | output | 1 | Current lock bit of the control register |

## Verification
`err_o` is combinational and is due in the same cycle as the write that causes it. `rdata_o` is also combinational and follows the address in that cycle. `locked_o` and the stored fields change at the clock edge that captures the write, so they are due one cycle later. The driver stamps each expected item with the cycle it is due: the current cycle for errors and reads, and the next cycle for the lock. The monitor compares items only in the cycle stamped on them, shortly after the falling edge, once the inputs have settled.

// File: rtl/klc_pkg.sv
package klc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LOCK_BIT = DATA_W - 1;
  typedef logic [DATA_W-1:0] word_t;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_DEAD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/klc_addr_dec.sv
module klc_addr_dec
  import klc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned FIELD_W  = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'h4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lock_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic              key_we_o,
  output logic              ctrl_we_o,
  output word_t             rdata_o
);
  localparam int unsigned PAD_W = DATA_W - 1 - FIELD_W;

  assign key_we_o  = we_i && (addr_i == KEY_ADDR);
  assign ctrl_we_o = we_i && (addr_i == CTRL_ADDR);

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) rdata_o = {lock_i, {PAD_W{1'b0}}, field_i};
  end
endmodule

// File: rtl/klc_key_seq.sv
module klc_key_seq
  import klc_pkg::*;
#(
  parameter word_t KEY_A = 32'h4567_0123,
  parameter word_t KEY_B = 32'hCDEF_89AB
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  key_we_i,
  input  word_t key_data_i,
  input  logic  lock_i,
  output logic  unlock_o,
  output logic  fault_o,
  output logic  hard_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    unlock_o = 1'b0;
    fault_o  = 1'b0;
    if (key_we_i) begin
      unique case (state_q)
        SEQ_DEAD: fault_o = 1'b1;
        SEQ_IDLE: begin
          if (lock_i) begin
            if (key_data_i == KEY_A) state_d = SEQ_ARMED;
            else begin
              fault_o = 1'b1;
              state_d = SEQ_DEAD;
            end
          end
        end
        SEQ_ARMED: begin
          if (lock_i) begin
            if (key_data_i == KEY_B) begin
              unlock_o = 1'b1;
              state_d  = SEQ_IDLE;
            end else begin
              fault_o = 1'b1;
              state_d = SEQ_DEAD;
            end
          end
        end
        default: state_d = SEQ_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign hard_o = (state_q == SEQ_DEAD);

  // R4: hard lock never leaves without reset
  a_r4_dead_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_o |=> hard_o);
  // R3: a fault always lands in the hard lock
  a_r3_fault_to_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> hard_o);
  // R2: an unlock never comes from the hard lock
  a_r2_unlock_not_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> !hard_o);
endmodule

// File: rtl/klc_ctrl_reg.sv
module klc_ctrl_reg
  import klc_pkg::*;
#(
  parameter int unsigned FIELD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  word_t              wdata_i,
  input  logic               unlock_i,
  output logic               lock_o,
  output logic [FIELD_W-1:0] field_o
);
  logic               lock_q;
  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b1;
      field_q <= '0;
    end else if (unlock_i) begin
      lock_q <= 1'b0;
    end else if (ctrl_we_i && !lock_q) begin
      lock_q  <= wdata_i[LOCK_BIT];
      field_q <= wdata_i[FIELD_W-1:0];
    end
  end

  assign lock_o  = lock_q;
  assign field_o = field_q;

  // R8: fields frozen while locked
  a_r8_field_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(field_q));
  // R7: writing the lock bit closes the register
  a_r7_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[LOCK_BIT]) |=> lock_q);
endmodule

// File: rtl/key_lock_ctrl.sv
module key_lock_ctrl
  import klc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned FIELD_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'h4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h8,
  parameter logic [31:0] KEY_A = 32'h4567_0123,
  parameter logic [31:0] KEY_B = 32'hCDEF_89AB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              locked_o
);
  logic               key_we, ctrl_we, unlock, fault, hard, lock;
  logic [FIELD_W-1:0] field;

  klc_addr_dec #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
    .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .we_i(we_i), .addr_i(addr_i), .lock_i(lock), .field_i(field),
    .key_we_o(key_we), .ctrl_we_o(ctrl_we), .rdata_o(rdata_o)
  );

  klc_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_we_i(key_we), .key_data_i(wdata_i),
    .lock_i(lock), .unlock_o(unlock), .fault_o(fault), .hard_o(hard)
  );

  klc_ctrl_reg #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .wdata_i(wdata_i),
    .unlock_i(unlock), .lock_o(lock), .field_o(field)
  );

  assign err_o    = fault;
  assign locked_o = lock;

  // R4: hard lock keeps the register closed
  a_r4_hard_keeps_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard |-> lock);
  // R2: lock only drops right after a second-key write
  a_r2_fall_after_key_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock) |-> $past(key_we && (wdata_i == KEY_B)));
  // R9: key writes while open never fault
  a_r9_no_err_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we && !lock) |-> !err_o);
endmodule

// File: tb/tb_key_lock_ctrl.sv
module tb_key_lock_ctrl;
  localparam logic [3:0]  KA  = 4'h4;
  localparam logic [3:0]  CA  = 4'h8;
  localparam logic [31:0] K1  = 32'h4567_0123;
  localparam logic [31:0] K2  = 32'hCDEF_89AB;
  localparam int SEL_ERR = 0, SEL_LOCK = 1, SEL_RD = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic err_o, locked_o;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;
  int q_cyc[$];
  int q_sel[$];
  logic [31:0] q_exp[$];
  string q_req[$];

  key_lock_ctrl dut (.clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
                     .rdata_o, .err_o, .locked_o);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic push(int c, int s, logic [31:0] e, string r);
    q_cyc.push_back(c); q_sel.push_back(s); q_exp.push_back(e); q_req.push_back(r);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, bit e_err, bit e_lock, string r);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    push(cyc, SEL_ERR, {31'b0, e_err}, r);
    push(cyc + 1, SEL_LOCK, {31'b0, e_lock}, r);
  endtask

  task automatic rd(logic [31:0] e, string r);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = CA; wdata_i = '0;
    push(cyc, SEL_RD, e, r);
    push(cyc, SEL_ERR, 32'd0, r);
  endtask

  task automatic chk_lock(bit e, string r);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = '0;
    push(cyc, SEL_LOCK, {31'b0, e}, r);
  endtask

  task automatic do_reset();
    wait (q_cyc.size() == 0);
    @(negedge clk_i);
    we_i = 1'b0; rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor
  always @(negedge clk_i) begin
    #2;
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      automatic int s = q_sel.pop_front();
      automatic int c = q_cyc.pop_front();
      automatic logic [31:0] e = q_exp.pop_front();
      automatic string r = q_req.pop_front();
      automatic logic [31:0] act;
      act = (s == SEL_ERR) ? {31'b0, err_o} : (s == SEL_LOCK) ? {31'b0, locked_o} : rdata_o;
      checks++;
      if (c != cyc || act !== e) begin
        errors++;
        $display("FAIL %s sel=%0d cyc=%0d due=%0d actual=%h expected=%h", r, s, cyc, c, act, e);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_lock(1'b1, "R1");
    rd(32'h8000_0000, "R1");
    wr(CA, 32'h0000_1234, 1'b0, 1'b1, "R8");
    rd(32'h8000_0000, "R8");
    wr(KA, K1, 1'b0, 1'b1, "R2");
    wr(KA, K2, 1'b0, 1'b0, "R2");
    rd(32'h0000_0000, "R2");
    wr(CA, 32'h0000_ABCD, 1'b0, 1'b0, "R10");
    rd(32'h0000_ABCD, "R10");
    wr(KA, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9");
    wr(KA, K1, 1'b0, 1'b0, "R9");
    rd(32'h0000_ABCD, "R9");
    wr(CA, 32'h8000_0055, 1'b0, 1'b1, "R7");
    rd(32'h8000_0055, "R7");
    wr(CA, 32'h0000_0000, 1'b0, 1'b1, "R8");
    rd(32'h8000_0055, "R8");
    wr(KA, K1, 1'b0, 1'b1, "R12");
    wr(CA, 32'h0000_0077, 1'b0, 1'b1, "R12");
    wr(KA, K2, 1'b0, 1'b0, "R12");
    rd(32'h0000_0055, "R12");
    wr(CA, 32'h8000_0055, 1'b0, 1'b1, "R7");
    wr(KA, K2, 1'b1, 1'b1, "R5");
    wr(KA, K1, 1'b1, 1'b1, "R4");
    wr(KA, K2, 1'b1, 1'b1, "R4");
    rd(32'h8000_0055, "R4");
    do_reset();
    rd(32'h8000_0000, "R11");
    wr(KA, K1, 1'b0, 1'b1, "R6");
    wr(KA, K1, 1'b1, 1'b1, "R6");
    do_reset();
    wr(KA, 32'hFFFF_FFFF, 1'b1, 1'b1, "R3");
    chk_lock(1'b1, "R3");
    rd(32'h8000_0000, "R3");
    do_reset();
    wr(KA, K1, 1'b0, 1'b1, "R11");
    wr(KA, K2, 1'b0, 1'b0, "R11");
    rd(32'h0000_0000, "R11");
    wait (q_cyc.size() == 0);
    @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule